// File: doc/BRIEF.md
# Memory-Swept Direct Digital Synthesizer

This block is a phase-accumulator synthesizer. Its frequency tuning word, or its phase offset, can come from a small on-chip word memory instead of from a register input. An address counter sweeps that memory between a programmable first and last address, which turns a table of stored words into a frequency hop sequence or a phase pattern. The memory is loaded through a plain synchronous write port before a sweep starts.

The outputs are the accumulator's top bit and a truncated phase word. The phase word drives a sine lookup table that sits outside the block. By default the counter steps once per clock. In tuning-word mode it can instead step on each rising edge of the accumulator top bit. The synthesizer then holds each stored frequency for one whole output period before it moves to the next.

Top module: `sweep_dds`

## Requirements
- R1: While `rst_n` is low, the accumulator and the sweep address are zero and `msb_out` is 0. The phase output then equals the top `OUT_W` bits of the selected phase offset.
- R2: With `mem_en` = 0, the accumulator grows by `reg_ftw` on every clock and `reg_phase` is the phase offset. Memory contents have no effect on the outputs.
- R3: `phase_out` is the top `OUT_W` (12) bits of the 16-bit sum of the accumulator's top 16 bits and the offset, taken modulo 2^16. `msb_out` is bit 23 of the 24-bit accumulator.
- R4: A high `wr_en` at a clock edge stores `wr_data` at `wr_addr`.
- R5: With `mem_en` = 1 and `mem_phase` = 0, the full 24-bit word at the current sweep address is the tuning word. A new address first adds its word at the clock edge after the edge that selected it.
- R6: When stepping on the clock, the sweep address advances by one per edge and returns from `end_addr` to `start_addr`.
- R7: With `mem_en` = 1, `mem_phase` = 0 and `step_on_msb` = 1, the address steps only at an edge where `msb_out` is 1 and was 0 at the previous edge. At every other edge it holds.
- R8: With `mem_en` = 1 and `mem_phase` = 1, the low 16 bits of the addressed word are the phase offset and `reg_ftw` is the tuning word. The address steps on every clock whatever the value of `step_on_msb`.
- R9: With `mem_en` = 0, the sweep address is reloaded from `start_addr` at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_ftw | input | 24 | Register tuning word |
| reg_phase | input | 16 | Register phase offset (full circle) |
| mem_en | input | 1 | Take one operand from the swept memory |
| mem_phase | input | 1 | 1: memory supplies phase offset; 0: memory supplies tuning word |
| step_on_msb | input | 1 | Step address on accumulator top-bit rise (tuning-word mode only) |
| start_addr | input | 4 | First address of the sweep |
| end_addr | input | 4 | Last address of the sweep |
| wr_en | input | 1 | Memory write strobe |
| wr_addr | input | 4 | Memory write address |
| wr_data | input | 24 | Memory write data |
| msb_out | output | 1 | Accumulator top bit |
| phase_out | output | 12 | Truncated phase word for a sine table |

## Verification
The address assertions assume that `start_addr` is not above `end_addr` and that both stay steady while a sweep runs. Under these assumptions the wrap and stepping rules describe a closed window. The stimulus meets them by setting the window and the mode while `mem_en` is low, and only then raising `mem_en`. Memory writes take place only while no sweep reads the words being written. Every expected value is an accumulator sum worked out by hand from the stored words, so the tuning words are chosen to land on whole steps of the 16-bit phase word.

// File: rtl/sweep_dds_pkg.sv
package sweep_dds_pkg;

   typedef enum logic [1:0] {
      SRC_REG       = 2'd0,
      SRC_MEM_FTW   = 2'd1,
      SRC_MEM_PHASE = 2'd2
   } dds_src_e;

   function automatic dds_src_e pick_src(input logic use_mem, input logic mem_is_phase);
      if (!use_mem)
         return SRC_REG;
      else if (mem_is_phase)
         return SRC_MEM_PHASE;
      else
         return SRC_MEM_FTW;
   endfunction

endpackage

// File: rtl/sweep_dds_wavemem.sv
module sweep_dds_wavemem #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         store[wr_addr] <= wr_data;
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/sweep_dds_addrgen.sv
module sweep_dds_addrgen #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sweep_en,
   input  logic              msb_mode,
   input  logic              msb,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] end_addr,
   output logic [ADDR_W-1:0] addr
);
   logic msb_prev;
   logic msb_rise;
   logic step;

   assign msb_rise = msb & ~msb_prev;
   assign step     = msb_mode ? msb_rise : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         msb_prev <= 1'b0;
      end else begin
         msb_prev <= msb;
         if (!sweep_en)
            addr <= start_addr;
         else if (step)
            addr <= (addr == end_addr) ? start_addr : addr + 1'b1;
      end
   end

   // R6: last address returns to the first when stepping on the clock
   a_r6_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_en && !msb_mode && addr == end_addr |=> addr == $past(start_addr));

   // R7: without a top-bit rise the address holds in top-bit mode
   a_r7_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_en && msb_mode && !(msb && !msb_prev) |=> $stable(addr));

   // R9: idle sweep reloads the first address
   a_r9_reload_start: assert property (@(posedge clk) disable iff (!rst_n)
      !sweep_en |=> addr == $past(start_addr));

endmodule

// File: rtl/sweep_dds_phasecore.sv
module sweep_dds_phasecore #(
   parameter int ACC_W = 24,
   parameter int PH_W  = 16,
   parameter int OUT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] ftw,
   input  logic [PH_W-1:0]  ph_off,
   output logic             msb,
   output logic [OUT_W-1:0] phase_out
);
   localparam int DROP = PH_W - OUT_W;

   logic [ACC_W-1:0] acc;
   logic [PH_W-1:0]  ph_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else
         acc <= acc + ftw;
   end

   assign msb    = acc[ACC_W-1];
   assign ph_sum = acc[ACC_W-1 -: PH_W] + ph_off;

   generate
      if (DROP == 0) begin : g_full
         assign phase_out = ph_sum;
      end else begin : g_trunc
         assign phase_out = OUT_W'(ph_sum >> DROP);
      end
   endgenerate

endmodule

// File: rtl/sweep_dds.sv
module sweep_dds
   import sweep_dds_pkg::*;
#(
   parameter int ACC_W  = 24,
   parameter int PH_W   = 16,
   parameter int OUT_W  = 12,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  reg_ftw,
   input  logic [PH_W-1:0]   reg_phase,
   input  logic              mem_en,
   input  logic              mem_phase,
   input  logic              step_on_msb,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] end_addr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   output logic              msb_out,
   output logic [OUT_W-1:0]  phase_out
);
   generate
      if (PH_W > ACC_W) begin : g_bad_ph
         $error("phase offset wider than accumulator");
      end
      if (OUT_W > PH_W || OUT_W < 1) begin : g_bad_out
         $error("output width must be 1..PH_W");
      end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("address width out of range");
      end
   endgenerate

   dds_src_e          src;
   logic [ADDR_W-1:0] addr;
   logic [ACC_W-1:0]  mem_q;
   logic [ACC_W-1:0]  ftw_sel;
   logic [PH_W-1:0]   ph_sel;
   logic              msb_mode;

   assign src      = pick_src(mem_en, mem_phase);
   assign msb_mode = step_on_msb && (src == SRC_MEM_FTW);

   always_comb begin
      ftw_sel = reg_ftw;
      ph_sel  = reg_phase;
      case (src)
         SRC_MEM_FTW:   ftw_sel = mem_q;
         SRC_MEM_PHASE: ph_sel  = mem_q[PH_W-1:0];
         default: ;
      endcase
   end

   sweep_dds_wavemem #(.ADDR_W(ADDR_W), .DATA_W(ACC_W)) u_mem (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(addr), .rd_data(mem_q)
   );

   sweep_dds_addrgen #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .sweep_en(mem_en), .msb_mode(msb_mode),
      .msb(msb_out), .start_addr(start_addr), .end_addr(end_addr), .addr(addr)
   );

   sweep_dds_phasecore #(.ACC_W(ACC_W), .PH_W(PH_W), .OUT_W(OUT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .ftw(ftw_sel), .ph_off(ph_sel),
      .msb(msb_out), .phase_out(phase_out)
   );

   // R8: phase-memory mode steps every clock even with top-bit stepping requested
   a_r8_phase_mode_steps: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en && mem_phase && addr != end_addr |=> addr == ADDR_W'($past(addr) + 1'b1));

endmodule

// File: tb/sweep_dds_test.sv
`timescale 1ns/1ps
module sweep_dds_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] reg_ftw = '0;
   logic [15:0] reg_phase = '0;
   logic        mem_en = 1'b0;
   logic        mem_phase = 1'b0;
   logic        step_on_msb = 1'b0;
   logic [3:0]  start_addr = '0;
   logic [3:0]  end_addr = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [23:0] wr_data = '0;
   logic        msb_out;
   logic [11:0] phase_out;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   sweep_dds uut (
      .clk(clk), .rst_n(rst_n), .reg_ftw(reg_ftw), .reg_phase(reg_phase),
      .mem_en(mem_en), .mem_phase(mem_phase), .step_on_msb(step_on_msb),
      .start_addr(start_addr), .end_addr(end_addr), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .msb_out(msb_out), .phase_out(phase_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; mem_en = 1'b0; reg_ftw = '0;
      wait_cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic mem_write(input logic [3:0] a, input logic [23:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_phase = 16'h1230;
      wait_cyc(2);
      check("R1 msb in reset", 32'(msb_out), 32'd0);
      check("R1 phase in reset", 32'(phase_out), 32'h123);
      rst_n = 1'b1;
   endtask

   task automatic t_register();
      mem_write(4'd0, 24'h7FFFFF);
      do_reset();
      reg_phase = 16'h0000; reg_ftw = 24'h001000;
      wait_cyc(10);
      check("R2 register tuning", 32'(phase_out), 32'h00A);
      check("R3 msb low", 32'(msb_out), 32'd0);
      reg_phase = 16'hFFF0;
      #0.1;
      check("R3 offset wraps", 32'(phase_out), 32'h009);
   endtask

   task automatic t_sweep_clock();
      mem_write(4'd0, 24'h010000);
      mem_write(4'd1, 24'h020000);
      mem_write(4'd2, 24'h030000);
      mem_write(4'd3, 24'h040000);
      do_reset();
      reg_phase = '0; mem_phase = 1'b0; step_on_msb = 1'b0;
      start_addr = 4'd0; end_addr = 4'd3;
      mem_en = 1'b1;
      wait_cyc(4);
      check("R4 R5 sum of four words", 32'(phase_out), 32'h0A0);
      wait_cyc(2);
      check("R6 wrap to start", 32'(phase_out), 32'h0D0);
   endtask

   task automatic t_sweep_msb();
      mem_write(4'd0, 24'h400000);
      mem_write(4'd1, 24'h100000);
      do_reset();
      reg_phase = '0; mem_phase = 1'b0; step_on_msb = 1'b1;
      start_addr = 4'd0; end_addr = 4'd1;
      mem_en = 1'b1;
      wait_cyc(4);
      check("R7 dwell on first word", 32'(phase_out), 32'hD00);
      wait_cyc(11);
      check("R7 msb risen", 32'(msb_out), 32'd1);
      check("R7 second word held", 32'(phase_out), 32'h800);
      wait_cyc(1);
      check("R7 still second word", 32'(phase_out), 32'h900);
      wait_cyc(1);
      check("R7 back to first word", 32'(phase_out), 32'hD00);
   endtask

   task automatic t_phase_mem();
      mem_write(4'd4, 24'h0000A0);
      mem_write(4'd5, 24'h000B00);
      mem_write(4'd6, 24'h00C000);
      do_reset();
      reg_ftw = '0; reg_phase = '0; mem_phase = 1'b1; step_on_msb = 1'b1;
      start_addr = 4'd4; end_addr = 4'd6;
      wait_cyc(2);
      check("R9 reload start", 32'(phase_out), 32'h000);
      mem_en = 1'b1;
      #0.1;
      check("R8 first offset", 32'(phase_out), 32'h00A);
      wait_cyc(1);
      check("R8 steps on clock", 32'(phase_out), 32'h0B0);
      wait_cyc(1);
      check("R8 third offset", 32'(phase_out), 32'hC00);
      wait_cyc(1);
      check("R8 R6 wrap", 32'(phase_out), 32'h00A);
      mem_en = 1'b0;
      mem_phase = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_register();
      t_sweep_clock();
      t_sweep_msb();
      t_phase_mem();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule